// File: doc/BRIEF.md
# Bang-Bang Loop Controller with Split Frequency and Phase Paths

This block is the digital loop controller of an integer-N phase-locked loop that uses a one-bit early/late phase decision. A system clock runs it. A one-cycle strobe marks each reference edge. Before lock, the block runs a frequency path: it counts divided-oscillator edges over a fixed window of reference ticks and compares the count against a programmed target. That comparison settles three coarse capacitor codes in a fixed order. The wide-range code is found first by successive approximation, the acquisition code next by single steps, and the tracking code last by single steps. Each code is frozen before work on the next one begins.

Lock is declared when the tracking stage sees a run of windows with zero count error. From then on the frequency path is switched off and its enable output drops. The phase path takes over. The latest early/late decision drives a single fine tuning bit, and the fine bit is let through only for a short pulse after each reference tick, which scales its effective weight by the duty cycle. The early/late decisions are also summed with a right-shift gain that can be set at run time. Each time the sum overflows, the tracking code moves by one, so the fine bit stays near the centre of its range.

Top module: `bbpll_loop_ctrl`

## Requirements
- R1: During and after a synchronous reset, all three coarse codes equal mid-code (2^(BW-1), 32 for BW=6), `locked` is 0, `fd_enable` is 1 and `fine_out` is 0.
- R2: The frequency path counts `div_edge` pulses over windows of WIN=64 reference ticks, starting with the first tick after reset, and compares the count with `n_target` at the end of each window.
- R3: The wide-range code is resolved by successive approximation, MSB first, one bit per window. A trial bit is kept when the count is not above the target and cleared otherwise. With the other codes at mid-code, the result is the largest code whose count does not exceed the target.
- R4: The acquisition code then moves by +1 when the count is low and by -1 when it is high, one step per window. It freezes, and tracking starts, on a zero error, a reversal of direction or a limit.
- R5: The tracking code moves by ±1 per window in the same way. After LOCK_WINS=4 consecutive zero-error windows, `locked` rises.
- R6: While locked, `fd_enable` is 0. `div_edge` and `n_target` are ignored, and the wide-range and acquisition codes hold their values.
- R7: While locked, `fine_out` equals the `bpd_late` value sampled at the most recent reference tick (1 means the oscillator lags). It is asserted only during the PW=2 cycles that follow each tick, so it is high for 1/3 of a 6-cycle reference period. Before lock, `fine_out` is 0.
- R8: While locked, each reference tick adds +1 (late) or -1 (early) to an integral sum. When the sum reaches +2^ki_shift, `trk_code` increments. When it reaches -2^ki_shift, `trk_code` decrements. In both cases the sum clears. `ki_shift` ranges from 0 to 7.
- R9: `trk_code` saturates at 0 and at 2^BW-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference edge |
| bpd_late | input | 1 | Phase decision: 1 = oscillator late, 0 = early |
| div_edge | input | 1 | One-cycle strobe per divided-oscillator edge |
| n_target | input | CW | Expected divided-edge count per window |
| ki_shift | input | 3 | Integral gain as a right shift (0..7) |
| pvt_code | output | BW | Wide-range coarse bank code |
| acq_code | output | BW | Acquisition coarse bank code |
| trk_code | output | BW | Tracking coarse bank code |
| fine_out | output | 1 | Pulse-gated fine bank bit |
| fd_enable | output | 1 | Frequency path power enable |
| locked | output | 1 | Lock indicator |

## Verification
The assertions rely on three conditions on the inputs: `ref_tick` is a one-cycle strobe separated by idle cycles, `div_edge` pulses stay within a window's counter range, and `ki_shift` is held steady while the integral sum is running. The bench meets all three. Its reference ticks come every six cycles. Its divided-edge bursts come from an affine model of the three codes and fit inside a single window. It changes the gain only between measurements, and each measurement first resynchronises on an overflow.

// File: rtl/bbpll_pkg.sv
package bbpll_pkg;
  typedef enum logic [1:0] {
    ST_PVT  = 2'd0,
    ST_ACQ  = 2'd1,
    ST_TRK  = 2'd2,
    ST_LOCK = 2'd3
  } loop_st_t;
endpackage

// File: rtl/bbpll_freq_win.sv
module bbpll_freq_win #(
  parameter int WIN = 64,
  parameter int CW  = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ref_tick,
  input  logic          div_edge,
  input  logic [CW-1:0] n_target,
  output logic          win_done,
  output logic          slow,
  output logic          fast
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [WW-1:0] tick_cnt;
  logic [CW-1:0] edge_cnt;
  logic [CW-1:0] edge_now;
  logic          last_tick;

  always_comb begin
    edge_now  = (div_edge && edge_cnt != '1) ? edge_cnt + 1'b1 : edge_cnt;
    last_tick = ref_tick && (tick_cnt == WW'(WIN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tick_cnt <= '0;
      edge_cnt <= '0;
      win_done <= 1'b0;
      slow     <= 1'b0;
      fast     <= 1'b0;
    end else begin
      win_done <= last_tick;
      if (last_tick) begin
        tick_cnt <= '0;
        edge_cnt <= '0;
        slow     <= edge_now < n_target;
        fast     <= edge_now > n_target;
      end else begin
        edge_cnt <= edge_now;
        if (ref_tick) tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  a_r2_sign_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(slow && fast));
  a_r2_done_needs_tick: assert property (@(posedge clk) disable iff (rst)
    win_done |-> $past(ref_tick));
endmodule

// File: rtl/bbpll_coarse_seq.sv
module bbpll_coarse_seq
  import bbpll_pkg::*;
#(
  parameter int BW        = 6,
  parameter int LOCK_WINS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_done,
  input  logic          slow,
  input  logic          fast,
  input  logic          trk_inc,
  input  logic          trk_dec,
  output loop_st_t      state,
  output logic [BW-1:0] pvt,
  output logic [BW-1:0] acq,
  output logic [BW-1:0] trk
);
  localparam int BIW = $clog2(BW);
  localparam int LW  = $clog2(LOCK_WINS + 1);
  localparam logic [BW-1:0] MID  = BW'(1) << (BW - 1);
  localparam logic [BW-1:0] MAXC = '1;

  logic [BIW-1:0] bit_idx;
  logic [BIW-1:0] bit_m1;
  logic [LW-1:0]  zero_cnt;
  logic           have_dir;
  logic           last_up;
  logic           zero_err;

  always_comb begin
    bit_m1   = bit_idx - 1'b1;
    zero_err = !slow && !fast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PVT;
      pvt      <= MID;
      acq      <= MID;
      trk      <= MID;
      bit_idx  <= BIW'(BW - 1);
      zero_cnt <= '0;
      have_dir <= 1'b0;
      last_up  <= 1'b0;
    end else begin
      case (state)
        ST_PVT: if (win_done) begin
          if (fast) pvt[bit_idx] <= 1'b0;
          if (bit_idx == '0) state <= ST_ACQ;
          else begin
            pvt[bit_m1] <= 1'b1;
            bit_idx     <= bit_m1;
          end
        end
        ST_ACQ: if (win_done) begin
          if (zero_err || (have_dir && last_up != slow) ||
              (slow && acq == MAXC) || (fast && acq == '0)) begin
            state <= ST_TRK;
          end else begin
            acq      <= slow ? acq + 1'b1 : acq - 1'b1;
            have_dir <= 1'b1;
            last_up  <= slow;
          end
        end
        ST_TRK: if (win_done) begin
          if (zero_err) begin
            if (zero_cnt == LW'(LOCK_WINS - 1)) state <= ST_LOCK;
            else zero_cnt <= zero_cnt + 1'b1;
          end else begin
            zero_cnt <= '0;
            if (slow && trk != MAXC) trk <= trk + 1'b1;
            else if (fast && trk != '0) trk <= trk - 1'b1;
          end
        end
        default: begin
          if (trk_inc && trk != MAXC) trk <= trk + 1'b1;
          else if (trk_dec && trk != '0) trk <= trk - 1'b1;
        end
      endcase
    end
  end

  a_r6_coarse_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && $past(state) == ST_LOCK) |-> ($stable(pvt) && $stable(acq)));
  a_r5_lock_from_trk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && $past(state) != ST_LOCK) |-> $past(state) == ST_TRK);
  a_r9_trk_no_wrap: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, trk} == {1'b0, $past(trk)}) ||
    ({1'b0, trk} == {1'b0, $past(trk)} + 1'b1) ||
    ({1'b0, trk} + 1'b1 == {1'b0, $past(trk)}));
endmodule

// File: rtl/bbpll_pi_fine.sv
module bbpll_pi_fine #(
  parameter int PW = 2,
  parameter int AW = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       ref_tick,
  input  logic       bpd_late,
  input  logic [2:0] ki_shift,
  output logic       trk_inc,
  output logic       trk_dec,
  output logic       fine_out
);
  localparam int GW = $clog2(PW + 1);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_n;
  logic signed [AW-1:0] thr;
  logic [GW-1:0]        gate_cnt;
  logic                 fine_q;

  always_comb begin
    thr   = $signed(AW'(1) << ki_shift);
    acc_n = bpd_late ? acc + AW'(1) : acc - AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      acc     <= '0;
      fine_q  <= 1'b0;
      trk_inc <= 1'b0;
      trk_dec <= 1'b0;
    end else begin
      trk_inc <= 1'b0;
      trk_dec <= 1'b0;
      if (ref_tick) begin
        fine_q <= bpd_late;
        if (acc_n >= thr) begin
          trk_inc <= 1'b1;
          acc     <= '0;
        end else if (acc_n <= -thr) begin
          trk_dec <= 1'b1;
          acc     <= '0;
        end else begin
          acc <= acc_n;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_cnt <= '0;
      fine_out <= 1'b0;
    end else begin
      if (ref_tick) gate_cnt <= GW'(PW);
      else if (gate_cnt != '0) gate_cnt <= gate_cnt - 1'b1;
      fine_out <= active && fine_q && (gate_cnt != '0);
    end
  end

  a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
    !(trk_inc && trk_dec));
  a_r8_step_after_tick: assert property (@(posedge clk) disable iff (rst)
    (trk_inc || trk_dec) |-> $past(ref_tick));
endmodule

// File: rtl/bbpll_loop_ctrl.sv
module bbpll_loop_ctrl
  import bbpll_pkg::*;
#(
  parameter int BW        = 6,
  parameter int CW        = 10,
  parameter int WIN       = 64,
  parameter int LOCK_WINS = 4,
  parameter int PW        = 2,
  parameter int AW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          bpd_late,
  input  logic          div_edge,
  input  logic [CW-1:0] n_target,
  input  logic [2:0]    ki_shift,
  output logic [BW-1:0] pvt_code,
  output logic [BW-1:0] acq_code,
  output logic [BW-1:0] trk_code,
  output logic          fine_out,
  output logic          fd_enable,
  output logic          locked
);
  loop_st_t state;
  logic     win_done, slow, fast, trk_inc, trk_dec;

  assign locked    = (state == ST_LOCK);
  assign fd_enable = !locked;

  bbpll_freq_win #(.WIN(WIN), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .en(fd_enable), .ref_tick(ref_tick),
    .div_edge(div_edge), .n_target(n_target),
    .win_done(win_done), .slow(slow), .fast(fast)
  );

  bbpll_coarse_seq #(.BW(BW), .LOCK_WINS(LOCK_WINS)) u_seq (
    .clk(clk), .rst(rst), .win_done(win_done), .slow(slow), .fast(fast),
    .trk_inc(trk_inc), .trk_dec(trk_dec), .state(state),
    .pvt(pvt_code), .acq(acq_code), .trk(trk_code)
  );

  bbpll_pi_fine #(.PW(PW), .AW(AW)) u_pi (
    .clk(clk), .rst(rst), .active(locked), .ref_tick(ref_tick),
    .bpd_late(bpd_late), .ki_shift(ki_shift),
    .trk_inc(trk_inc), .trk_dec(trk_dec), .fine_out(fine_out)
  );

  a_r6_no_window_in_lock: assert property (@(posedge clk) disable iff (rst)
    locked |-> !win_done);
  a_r7_fine_only_locked: assert property (@(posedge clk) disable iff (rst)
    fine_out |-> locked);
endmodule

// File: tb/bbpll_loop_ctrl_tb.sv
module bbpll_loop_ctrl_tb;
  localparam int BW = 6;
  localparam int CW = 10;
  localparam int REFP = 6;
  localparam int KI_TAB [5][2] = '{'{0, 1}, '{1, 2}, '{2, 4}, '{3, 8}, '{5, 32}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick, div_edge, bpd_late;
  logic [CW-1:0] n_target = CW'(151);
  logic [2:0]    ki_shift = 3'd3;
  logic [BW-1:0] pvt_code, acq_code, trk_code;
  logic          fine_out, fd_enable, locked;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int tick_k = 0;

  always #4 clk = ~clk;

  assign bpd_late = (mode == 2) ? tick_k[0] : (mode == 1);

  bbpll_loop_ctrl u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bpd_late(bpd_late),
    .div_edge(div_edge), .n_target(n_target), .ki_shift(ki_shift),
    .pvt_code(pvt_code), .acq_code(acq_code), .trk_code(trk_code),
    .fine_out(fine_out), .fd_enable(fd_enable), .locked(locked)
  );

  function automatic int model(int p, int a, int t);
    int v = 4 * p + 2 * a + t - 100;
    return (v < 0) ? 0 : v;
  endfunction

  initial begin
    int ph   = 0;
    int pend = 0;
    ref_tick = 1'b0;
    div_edge = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ph = 0; pend = 0; tick_k = 0;
        ref_tick = 1'b0; div_edge = 1'b0;
      end else begin
        ref_tick = (ph == 0);
        if (ref_tick) begin
          if (tick_k % 64 == 2) pend = model(pvt_code, acq_code, trk_code);
          tick_k++;
        end
        div_edge = (pend > 0);
        if (pend > 0) pend--;
        ph = (ph == REFP - 1) ? 0 : ph + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    check(pvt_code == 6'd32, "R1 pvt mid", pvt_code, 32);
    check(acq_code == 6'd32, "R1 acq mid", acq_code, 32);
    check(trk_code == 6'd32, "R1 trk mid", trk_code, 32);
    check(!locked && fd_enable && !fine_out, "R1 flags", {locked, fd_enable, fine_out}, 3'b010);
    rst = 1'b0;
  endtask

  task automatic wait_lock();
    int n = 0;
    while (!locked && n < 30000) begin step(); n++; end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin step(); if (ref_tick) c++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int exp_p, t0, ticks, hi;
    mode = 2;
    do_reset();
    // R2 R3 R4 R5: acquisition for target 151
    exp_p = 0;
    for (int p = 0; p < 64; p++) if (model(p, 32, 32) <= 151) exp_p = p;
    wait_lock();
    check(locked == 1'b1, "R5 lock reached", locked, 1);
    check(pvt_code == 6'(exp_p), "R3 sar result", pvt_code, exp_p);
    check(acq_code == 6'd34, "R4 acq freeze on reversal", acq_code, 34);
    check(trk_code == 6'd31, "R5 trk settle", trk_code, 31);
    check(model(pvt_code, acq_code, trk_code) == 151, "R2 zero error",
          model(pvt_code, acq_code, trk_code), 151);
    check(fd_enable == 1'b0, "R6 fd off", fd_enable, 0);

    // R6: frequency inputs ignored in lock
    begin
      logic [BW-1:0] p0, a0, k0;
      p0 = pvt_code; a0 = acq_code; k0 = trk_code;
      n_target = '0;
      wait_ticks(200);
      check(pvt_code == p0 && acq_code == a0, "R6 coarse hold", {pvt_code, acq_code}, {p0, a0});
      check(trk_code == k0, "R6 trk hold alt", trk_code, k0);
      n_target = CW'(151);
    end

    // R7: pulse-gated fine bit
    ki_shift = 3'd7;
    mode = 1;
    wait_ticks(3);
    hi = 0;
    for (int i = 0; i < 60; i++) begin step(); if (fine_out) hi++; end
    check(hi == 20, "R7 duty one third", hi, 20);
    mode = 0;
    wait_ticks(3);
    hi = 0;
    for (int i = 0; i < 60; i++) begin step(); if (fine_out) hi++; end
    check(hi == 0, "R7 early gives zero", hi, 0);

    // R8: ticks per tracking step versus gain shift
    for (int i = 0; i < 5; i++) begin
      int n;
      ki_shift = 3'(KI_TAB[i][0]);
      mode = 0;
      t0 = trk_code; n = 0;
      while (trk_code == 6'(t0) && n < 5000) begin step(); n++; end
      mode = 1;
      t0 = trk_code; ticks = 0; n = 0;
      while (trk_code == 6'(t0) && n < 5000) begin step(); n++; if (ref_tick) ticks++; end
      check(ticks == KI_TAB[i][1], "R8 ki step interval", ticks, KI_TAB[i][1]);
      check(trk_code == 6'(t0 + 1), "R8 step up by one", trk_code, t0 + 1);
    end

    // R9: saturation at both limits
    ki_shift = 3'd0;
    mode = 1;
    wait_ticks(100);
    check(trk_code == 6'd63, "R9 top limit", trk_code, 63);
    mode = 0;
    wait_ticks(100);
    check(trk_code == 6'd0, "R9 bottom limit", trk_code, 0);

    // R1 R3 R4: reset from lock, then second target with exact hit
    mode = 2;
    n_target = CW'(100);
    do_reset();
    wait_lock();
    check(locked == 1'b1, "R5 second lock", locked, 1);
    check(pvt_code == 6'd26, "R3 sar exact", pvt_code, 26);
    check(acq_code == 6'd32 && trk_code == 6'd32, "R4 no move on zero error",
          {acq_code, trk_code}, {6'd32, 6'd32});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule